// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block collects sixteen level-sensitive interrupt requests. Each request can be switched off at its source, and each source carries a four-bit priority that software sets. The block drives a single request line to the processor. That line is high whenever an enabled, pending source has a priority strictly greater than the priority of the handler now running. The running priority lives in a current-priority register. When a higher-priority request is taken, the old value is saved on a hidden last-in, first-out stack. When the handler finishes, an end-of-interrupt write restores the saved value. Nested handlers therefore unwind in order.

Software reaches the block through a small register bus. The bus exposes the per-source priority registers, the current-priority register, an acknowledge register (read) and an end-of-interrupt register (write). The block has two vector modes:

- In software vector mode, reading the acknowledge register takes the interrupt. The read returns the winning source number, saves the old priority and raises the current priority.
- In hardware vector mode, the processor takes the interrupt with a one-cycle acknowledge pulse. It finds the winning source number on a dedicated vector output. A register read of the acknowledge register in this mode only reports the source number and changes no state.

Top module: `nest_irq_ctrl`

## Requirements
- R1: `irq_out` is registered. One clock edge after an edge, `irq_out` is 1 exactly when, at that earlier edge, some source had `src_req`=1, `src_en`=1 and a priority strictly greater than the current priority.
- R2: A source with priority 0, or with a priority equal to or below the current priority, never raises `irq_out`, even while its request stays high.
- R3: A source with `src_en`=0 never contributes, whatever its priority.
- R4: Any bus write to address 18 (end of interrupt) loads the top stack entry into the current priority and removes that entry. If the stack is empty, the write loads 0.
- R5: In software vector mode (`vec_hw_mode`=0), a read of address 17 (acknowledge) returns the winning source number in `bus_rdata`. It also pushes the current priority onto the stack and sets the current priority to the winner's priority. If no source beats the current priority, the read returns 0xFF and changes nothing.
- R6: In hardware vector mode (`vec_hw_mode`=1), a read of address 17 returns the same vector value as in R5 but changes neither the stack nor the current priority.
- R7: In hardware vector mode, a one-cycle `hw_ack` pulse while a source beats the current priority pushes and updates exactly as in R5. While `irq_out` is 1, `irq_vec` holds the winning source number. In software vector mode, `hw_ack` is ignored.
- R8: Among sources that share the highest priority, the lowest-numbered source wins.
- R9: The stack holds 15 entries. A push into a full stack is dropped, but the current-priority update still happens. Each push or pop changes the stack depth by exactly one.
- R10: Address 16 is the current-priority register. A write sets it to `bus_wdata[3:0]`, and a read returns it zero-extended. A read result appears in `bus_rdata` one edge after the read.
- R11: Addresses 0 to 15 are the priority registers of sources 0 to 15, held in bits [3:0]. After reset, all priorities, the current priority, the stack depth and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 16 | Level request per source |
| src_en | input | 16 | Per-source enable at the source |
| vec_hw_mode | input | 1 | 1 = hardware vector mode, 0 = software vector mode |
| hw_ack | input | 1 | One-cycle acknowledge from the processor (hardware mode) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Winning source number |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Equal priority.** A source whose priority equals the current priority must not raise the request. A comparison written as "greater or equal" would re-interrupt a running handler.
- **Priority ties.** Several sources are given the same priority. A reversed scan would vector to the highest-numbered source instead of the lowest.
- **Full stack.** The stack is filled to all fifteen levels, and one more push is then forced through a direct current-priority write. A non-saturating stack would wrap and corrupt the unwinding. The stack is then drained past empty, which must yield zeros.
- **Acknowledge read in hardware mode.** The bench checks that this read leaves the stack untouched. A design that pushed here would return a wrong priority on the next end-of-interrupt.

// File: rtl/nest_pkg.sv
package nest_pkg;
  typedef enum logic [1:0] {
    CUR_HOLD,
    CUR_POP,
    CUR_SET,
    CUR_TAKE
  } cur_op_e;
endpackage

// File: rtl/nest_prio_regs.sv
module nest_prio_regs #(
  parameter int N_SRC = 16,
  parameter int PRI_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(N_SRC)-1:0] sel,
  input  logic [PRI_W-1:0]         wdata,
  output logic [N_SRC*PRI_W-1:0]   pri_flat
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_reg
    logic [PRI_W-1:0] pri_q;
    always_ff @(posedge clk) begin
      if (rst) pri_q <= '0;
      else if (we && sel == i[$clog2(N_SRC)-1:0]) pri_q <= wdata;
    end
    assign pri_flat[i*PRI_W +: PRI_W] = pri_q;
  end
endmodule

// File: rtl/nest_arbiter.sv
module nest_arbiter #(
  parameter int N_SRC = 16,
  parameter int PRI_W = 4
) (
  input  logic [N_SRC-1:0]         active,
  input  logic [N_SRC*PRI_W-1:0]   pri_flat,
  output logic                     best_valid,
  output logic [$clog2(N_SRC)-1:0] best_idx,
  output logic [PRI_W-1:0]         best_pri
);
  localparam int IDX_W = $clog2(N_SRC);

  // Scan downward and take on >= so that the lowest index wins a tie.
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_pri   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (active[i] && pri_flat[i*PRI_W +: PRI_W] != '0 &&
          pri_flat[i*PRI_W +: PRI_W] >= best_pri) begin
        best_valid = 1'b1;
        best_idx   = IDX_W'(i);
        best_pri   = pri_flat[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/nest_lifo.sv
module nest_lifo #(
  parameter int DEPTH = 15,
  parameter int W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               top,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0] mem [DEPTH];
  logic         full;
  logic         empty;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign top   = empty ? '0 : mem[CNT_W'(count - 1'b1)];

  // Storage has no reset so it may map onto RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[count] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (push && !full) count <= count + 1'b1;
    else if (pop && !empty) count <= count - 1'b1;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_SRC  = 16,
  parameter int PRI_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              src_req,
  input  logic [N_SRC-1:0]              src_en,
  input  logic                          vec_hw_mode,
  input  logic                          hw_ack,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [$clog2(N_SRC+3)-1:0]    bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          irq_out,
  output logic [$clog2(N_SRC)-1:0]      irq_vec
);
  import nest_pkg::*;

  localparam int IDX_W  = $clog2(N_SRC);
  localparam int ADDR_W = $clog2(N_SRC + 3);
  localparam int DEPTH  = (1 << PRI_W) - 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CUR = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(N_SRC + 1);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(N_SRC + 2);

  logic [N_SRC*PRI_W-1:0] pri_flat;
  logic                   best_valid;
  logic [IDX_W-1:0]       best_idx;
  logic [PRI_W-1:0]       best_pri;
  logic [PRI_W-1:0]       cur_pri;
  logic [PRI_W-1:0]       lifo_top;
  logic [CNT_W-1:0]       lifo_cnt;
  logic                   beats;
  logic                   in_pri_range;
  logic                   wr_pri, wr_cur, wr_eoi, rd_any, rd_ack;
  logic                   take_sw, take_hw;
  logic                   lifo_push, lifo_pop;
  cur_op_e                cur_op;

  assign in_pri_range = (bus_addr < ADDR_W'(N_SRC));
  assign wr_pri  = bus_sel && bus_wr && in_pri_range;
  assign wr_cur  = bus_sel && bus_wr && bus_addr == A_CUR;
  assign wr_eoi  = bus_sel && bus_wr && bus_addr == A_EOI;
  assign rd_any  = bus_sel && !bus_wr;
  assign rd_ack  = rd_any && bus_addr == A_ACK;

  nest_prio_regs #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_pri),
    .sel      (bus_addr[IDX_W-1:0]),
    .wdata    (bus_wdata[PRI_W-1:0]),
    .pri_flat (pri_flat)
  );

  nest_arbiter #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_arb (
    .active     (src_req & src_en),
    .pri_flat   (pri_flat),
    .best_valid (best_valid),
    .best_idx   (best_idx),
    .best_pri   (best_pri)
  );

  assign beats   = best_valid && (best_pri > cur_pri);
  assign take_sw = rd_ack && !vec_hw_mode && beats;
  assign take_hw = hw_ack && vec_hw_mode && beats;

  // One update per cycle: end of interrupt, then direct write, then a take.
  always_comb begin
    if (wr_eoi)                  cur_op = CUR_POP;
    else if (wr_cur)             cur_op = CUR_SET;
    else if (take_sw || take_hw) cur_op = CUR_TAKE;
    else                         cur_op = CUR_HOLD;
  end

  assign lifo_push = (cur_op == CUR_TAKE);
  assign lifo_pop  = (cur_op == CUR_POP);

  nest_lifo #(.DEPTH(DEPTH), .W(PRI_W)) u_lifo (
    .clk   (clk),
    .rst   (rst),
    .push  (lifo_push),
    .pop   (lifo_pop),
    .din   (cur_pri),
    .top   (lifo_top),
    .count (lifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_pri <= '0;
    else begin
      case (cur_op)
        CUR_POP:  cur_pri <= lifo_top;
        CUR_SET:  cur_pri <= bus_wdata[PRI_W-1:0];
        CUR_TAKE: cur_pri <= best_pri;
        default:  cur_pri <= cur_pri;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_out <= beats;
      irq_vec <= best_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_any) begin
      if (in_pri_range)
        bus_rdata <= DATA_W'(pri_flat[bus_addr[IDX_W-1:0]*PRI_W +: PRI_W]);
      else if (bus_addr == A_CUR)
        bus_rdata <= DATA_W'(cur_pri);
      else if (bus_addr == A_ACK)
        bus_rdata <= beats ? DATA_W'(best_idx) : '1;
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int N_SRC = 16,
  parameter int PRI_W = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [N_SRC-1:0]              src_en,
  input logic                          vec_hw_mode,
  input logic                          hw_ack,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [$clog2(N_SRC+3)-1:0]    bus_addr,
  input logic                          irq_out,
  input logic [PRI_W-1:0]              cur_pri,
  input logic [$clog2((1<<PRI_W))-1:0] depth
);
  localparam int ADDR_W = $clog2(N_SRC + 3);
  localparam int DEPTH  = (1 << PRI_W) - 1;
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(N_SRC + 1);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(N_SRC + 2);

  logic eoi_w, ack_r;
  assign eoi_w = bus_sel && bus_wr && bus_addr == A_EOI;
  assign ack_r = bus_sel && !bus_wr && bus_addr == A_ACK;

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> !irq_out);

  p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (eoi_w && depth == '0) |=> (cur_pri == '0));

  p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (rst)
    (eoi_w && depth != '0) |=> (depth == $past(depth) - 1'b1));

  p_hw_read_still_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_r && vec_hw_mode && !hw_ack) |=> ($stable(depth) && $stable(cur_pri)));

  p_push_raises_r5: assert property (@(posedge clk) disable iff (rst)
    (depth > $past(depth)) |-> (cur_pri > $past(cur_pri)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH[$bits(depth)-1:0]);

  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (depth != $past(depth)) |->
      (depth == $past(depth) + 1'b1 || depth == $past(depth) - 1'b1));
endmodule

bind nest_irq_ctrl nest_irq_chk #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_en      (src_en),
  .vec_hw_mode (vec_hw_mode),
  .hw_ack      (hw_ack),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .irq_out     (irq_out),
  .cur_pri     (cur_pri),
  .depth       (lifo_cnt)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [4:0] A_CUR = 5'd16;
  localparam logic [4:0] A_ACK = 5'd17;
  localparam logic [4:0] A_EOI = 5'd18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_req = '0;
  logic [15:0] src_en = '0;
  logic        vec_hw_mode = 1'b0;
  logic        hw_ack = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;
  logic [3:0]  irq_vec;

  int ntot = 0;
  int nbad = 0;
  bit finished = 0;

  int mpri [N];
  int mcur;
  int mstk [15];
  int mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
    .vec_hw_mode(vec_hw_mode), .hw_ack(hw_ack), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input int act, input int exp);
    ntot++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void mbest(output int idx, output int p);
    idx = -1; p = 0;
    for (int i = N - 1; i >= 0; i--)
      if (src_req[i] && src_en[i] && mpri[i] > 0 && mpri[i] >= p) begin
        idx = i; p = mpri[i];
      end
  endfunction

  function automatic bit mbeats();
    int idx, p;
    mbest(idx, p);
    return (idx >= 0) && (p > mcur);
  endfunction

  function automatic void mpush(input int v);
    if (mcnt < 15) begin mstk[mcnt] = v; mcnt++; end
  endfunction

  task automatic bus_write(input logic [4:0] a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = int'(bus_rdata);
  endtask

  task automatic set_src(input logic [15:0] rq, input logic [15:0] en);
    @(negedge clk);
    src_req = rq; src_en = en;
  endtask

  task automatic check_irq(input string req);
    int idx, p;
    @(negedge clk);
    mbest(idx, p);
    check(req, int'(irq_out), int'(mbeats()));
    if (mbeats()) check({req, "/R7 vec"}, int'(irq_vec), idx);
  endtask

  task automatic do_setpri(input int i, input int v);
    int d;
    bus_write(5'(i), v);
    mpri[i] = v;
    bus_read(5'(i), d);
    check("R11 pri readback", d, v);
  endtask

  task automatic do_setcur(input int v);
    int d;
    bus_write(A_CUR, v);
    mcur = v;
    bus_read(A_CUR, d);
    check("R10 cur readback", d, v);
  endtask

  task automatic do_eoi();
    int d;
    bus_write(A_EOI, 0);
    if (mcnt > 0) begin mcnt--; mcur = mstk[mcnt]; end
    else mcur = 0;
    bus_read(A_CUR, d);
    check("R4 pop to cur", d, mcur);
  endtask

  task automatic do_ack_read();
    int idx, p, d, e;
    bit b;
    mbest(idx, p);
    b = mbeats();
    e = b ? idx : 255;
    bus_read(A_ACK, d);
    check(vec_hw_mode ? "R6 ack vector" : "R5 ack vector", d, e);
    if (b && !vec_hw_mode) begin mpush(mcur); mcur = p; end
    bus_read(A_CUR, d);
    check(vec_hw_mode ? "R6 cur unchanged" : "R5 cur after ack", d, mcur);
  endtask

  task automatic do_hw_ack();
    int idx, p, d;
    mbest(idx, p);
    if (mbeats() && vec_hw_mode) begin mpush(mcur); mcur = p; end
    @(negedge clk); hw_ack = 1;
    @(negedge clk); hw_ack = 0;
    bus_read(A_CUR, d);
    check("R7 cur after hw ack", d, mcur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++; ntot++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    int d;
    d = int'($urandom(32'd4242));
    for (int i = 0; i < N; i++) mpri[i] = 0;
    mcur = 0; mcnt = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset state
    check("R11 irq after reset", int'(irq_out), 0);
    bus_read(A_CUR, d);  check("R11 cur after reset", d, 0);
    bus_read(5'd5, d);   check("R11 pri after reset", d, 0);

    // R2 priority zero never interrupts
    set_src(16'hFFFF, 16'hFFFF);
    check_irq("R2 zero priority");

    // R8 tie: lowest index wins
    do_setpri(9, 5); do_setpri(7, 5); do_setpri(3, 5);
    check_irq("R1 tie pending");
    do_ack_read();  // expects 3, cur=5
    check_irq("R2 equal to current");

    // R3 disabled source never contributes
    do_setpri(1, 9);
    set_src(16'h0002, 16'h0000);
    check_irq("R3 disabled high priority");
    set_src(16'h0002, 16'h0002);
    check_irq("R1 enabled high priority");

    // R4 pops, including pop on empty
    do_eoi();
    do_eoi();
    do_eoi();

    // R9 fill all fifteen levels then overflow
    for (int i = 0; i < N; i++) do_setpri(i, i);
    do_setcur(0);
    for (int k = 1; k < 16; k++) begin
      set_src(16'hFFFF, 16'(1 << k));
      do_ack_read();
    end
    do_setcur(1);
    set_src(16'hFFFF, 16'h0004);
    do_ack_read();  // push dropped, cur becomes 2
    for (int k = 0; k < 17; k++) do_eoi();

    // R6 / R7 hardware vector mode
    @(negedge clk); vec_hw_mode = 1;
    set_src(16'hFFFF, 16'h0300);
    check_irq("R7 hw pending");
    do_ack_read();
    do_hw_ack();
    check_irq("R7 after hw ack");
    do_eoi();
    @(negedge clk); vec_hw_mode = 0;
    do_hw_ack();  // ignored in software mode

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: set_src(16'($urandom), 16'($urandom));
        2:    do_setpri(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
        3, 4: do_ack_read();
        5, 6: do_eoi();
        7:    do_setcur(int'($urandom_range(0, 15)));
        8:    begin @(negedge clk); vec_hw_mode = ~vec_hw_mode; end
        default: do_hw_ack();
      endcase
      check_irq("R1 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule